// File: doc/BRIEF.md
# Sequenced-Kick Watchdog Timer

This block is a 16-bit timer that advances on a slow reference tick. It counts down or up and runs either as a plain timer or as a watchdog. As a plain timer, the count expiring sets an interrupt. As a watchdog, expiry either emits a one-cycle reset request or, if software selects it, raises the interrupt in place of the reset.

Software kicks the watchdog by writing to a clear port. When secure clearing is on, a kick counts only if its byte equals the next value of a hidden 8-bit sequence. Software seeds the sequence before it arms the watchdog and tracks it from then on. Any other byte causes a reset request at once, whatever the count is. Once the watchdog is armed, the control register is frozen until the next system reset.

Top module: `kickTimer`

## Requirements
- R1: `ctrlRdata` returns the last accepted control value in bits 8:0 and zero in bits 16:9. The prescaler field in bits 3:2 reads back as written, and every code in it divides the tick by one.
- R2: Each `tick` advances the count by one while enable (bit 7) is set. It counts down when bit 8 is 0 and up when bit 8 is 1. While bit 7 is clear, `tick` leaves the count unchanged.
- R3: While bit 0 is set and `pwrDown` is high, ticks are ignored. While bit 0 is clear, `pwrDown` has no effect.
- R4: A tick at the limit (0 counting down, 0xFFFF counting up) is an expiry. With bit 6 set, an expiry reloads the count from the load register. With bit 6 clear, the count wraps (0 to 0xFFFF, or 0xFFFF to 0).
- R5: A load write stores the value and copies it into the count on the same edge. Reset clears the count, the load value, the control register, `irq` and `wdReset`.
- R6: An expiry sets `irq` in timer mode, and also in watchdog mode when bit 1 is set. `irq` stays high until an accepted clear write.
- R7: In watchdog mode with bit 1 clear, an expiry raises `wdReset` on the next cycle and leaves `irq` unchanged.
- R8: A control write with bit 5 set arms the watchdog. After that, control writes are ignored until `rstN`.
- R9: A clear write is accepted whenever secure clearing (bit 4) is off or the watchdog is not yet armed. An accepted write reloads the count from the load register and clears `irq`. While the watchdog is not armed, the written byte also becomes the sequence seed.
- R10: When armed with secure clearing on, a kick equal to the expected byte is accepted. The sequence then steps: shift left one bit, and XOR with 0x63 if the bit shifted out was 1. From seed 0xAA the accepted kicks are 0xAA, 0x37, 0x6E, 0xDC, 0xDB.
- R11: When armed with secure clearing on, a kick that does not match raises `wdReset` on the next cycle. It leaves the count, `irq` and the expected byte unchanged.
- R12: A seed of 0x00 makes every kick count as a mismatch, including a kick of 0x00.
- R13: `wdReset` is high for exactly one cycle per pulse. A reset event in the cycle right after a pulse produces no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 9 | Control value (bits 8:0) |
| ctrlRdata | output | 17 | Control register readback |
| loadWe | input | 1 | Load register write strobe |
| loadWdata | input | 16 | Load value |
| clrWe | input | 1 | Clear/kick write strobe |
| clrWdata | input | 8 | Kick byte or seed |
| tick | input | 1 | Reference tick, one cycle per period |
| pwrDown | input | 1 | Peripheral power-down indication |
| count | output | 16 | Current count |
| irq | output | 1 | Timer/watchdog interrupt |
| wdReset | output | 1 | Watchdog reset request pulse |

## Verification
Assertions check on every cycle that the arming latch never drops, that the control register stays frozen once armed, and that a mismatched secure kick is followed by a reset pulse. They also check that pulses never stretch past one cycle, that a zero sequence stays zero, that an unarmed clear always drops the interrupt, and that load and step edges move the count as required. Only the bench scenarios can show the particular accepted sequence from seed 0xAA, the wrap and reload values at both count limits, the power-down gating, and the fact that a rejected kick leaves the expected byte in place so that the correct byte is still accepted afterwards. A behavioural model compares every output on every clock across all of these scenarios.

// File: rtl/kt_pkg.sv
package kt_pkg;
  localparam int CTRL_W    = 17;
  localparam int CTRL_USED = 9;

  localparam int B_UP     = 8;
  localparam int B_EN     = 7;
  localparam int B_PER    = 6;
  localparam int B_WD     = 5;
  localparam int B_SEC    = 4;
  localparam int B_PSHI   = 3;
  localparam int B_PSLO   = 2;
  localparam int B_IRQSEL = 1;
  localparam int B_PDSTOP = 0;

  typedef struct packed {
    logic reload;   // count <= load register
    logic loadCnt;  // count <= incoming load value
    logic loadWr;   // load register <= incoming load value
    logic step;     // advance count by one
    logic up;       // direction of step / limit selection
  } dpStrobes_t;
endpackage

// File: rtl/ktLfsrStep.sv
module ktLfsrStep #(
  parameter int                 W    = 8,
  parameter logic [W-1:0]       TAPS = 8'h63
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  // Left shift; feedback from the bit shifted out is folded into tap positions.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[i] = cur[W-1] & TAPS[i];
    end else begin : g_up
      assign nxt[i] = cur[i-1] ^ (cur[W-1] & TAPS[i]);
    end
  end
endmodule

// File: rtl/ktDatapath.sv
module ktDatapath
  import kt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] loadWdata,
  output logic [CNT_W-1:0] count,
  output logic             atLimit
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadReg <= '0;
      cnt     <= '0;
    end else begin
      if (strobes.loadWr) loadReg <= loadWdata;
      if (strobes.reload)       cnt <= loadReg;
      else if (strobes.loadCnt) cnt <= loadWdata;
      else if (strobes.step)    cnt <= strobes.up ? cnt + ONE : cnt - ONE;
    end
  end

  always_comb atLimit = strobes.up ? (&cnt) : (cnt == '0);
  assign count = cnt;

  // R5: load value copied into count
  a_r5_load_copy: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCnt && !strobes.reload) |=> (cnt == $past(loadWdata)));

  // R2: a down step lowers the count by one
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.reload && !strobes.up) |=> (cnt == $past(cnt) - ONE));

  // R2: an up step raises the count by one
  a_r2_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.reload && strobes.up) |=> (cnt == $past(cnt) + ONE));
endmodule

// File: rtl/ktControl.sv
module ktControl
  import kt_pkg::*;
#(
  parameter int              KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_TAPS = 8'h63
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWe,
  input  logic [CTRL_USED-1:0] ctrlWdata,
  input  logic                 clrWe,
  input  logic [KEY_W-1:0]     clrWdata,
  input  logic                 loadWe,
  input  logic                 tick,
  input  logic                 pwrDown,
  input  logic                 atLimit,
  output dpStrobes_t           strobes,
  output logic [CTRL_USED-1:0] ctrlQ,
  output logic                 irq,
  output logic                 wdReset
);
  logic [CTRL_USED-1:0] ctrlReg;
  logic                 locked;
  logic [KEY_W-1:0]     keyReg;
  logic [KEY_W-1:0]     keyNext;

  logic secure, kickMatch, kickOk, kickBad;
  logic tickEn, stepOk, expire, wdExpire, resetEvt;

  ktLfsrStep #(.W(KEY_W), .TAPS(KEY_TAPS)) u_keyStep (
    .cur(keyReg),
    .nxt(keyNext)
  );

  always_comb begin
    secure    = ctrlReg[B_SEC];
    // A zero key can never be matched.
    kickMatch = (clrWdata == keyReg) && (keyReg != '0);
    kickOk    = clrWe && (!locked || !secure || kickMatch);
    kickBad   = clrWe && locked && secure && !kickMatch;
    // Every prescaler code divides the tick by one.
    tickEn    = tick;
    stepOk    = tickEn && ctrlReg[B_EN] && !(ctrlReg[B_PDSTOP] && pwrDown);

    strobes.up      = ctrlReg[B_UP];
    strobes.loadWr  = loadWe;
    strobes.loadCnt = loadWe && !kickOk;
    strobes.step    = stepOk && !kickOk && !loadWe;
    expire          = strobes.step && atLimit;
    strobes.reload  = kickOk || (expire && ctrlReg[B_PER]);

    wdExpire = expire && locked && !ctrlReg[B_IRQSEL];
    resetEvt = kickBad || wdExpire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      locked  <= 1'b0;
      keyReg  <= '0;
      irq     <= 1'b0;
      wdReset <= 1'b0;
    end else begin
      if (ctrlWe && !locked) begin
        ctrlReg <= ctrlWdata;
        locked  <= ctrlWdata[B_WD];
      end
      if (clrWe && !locked)       keyReg <= clrWdata;
      else if (kickOk && secure)  keyReg <= keyNext;
      if (kickOk)                                         irq <= 1'b0;
      else if (expire && !(locked && !ctrlReg[B_IRQSEL])) irq <= 1'b1;
      wdReset <= resetEvt && !wdReset;
    end
  end

  assign ctrlQ = ctrlReg;

  // R8: arming cannot be undone
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R8: control frozen once armed
  a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(ctrlReg));

  // R11: a wrong secure kick requests reset
  a_r11_bad_kick: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && locked && secure && (clrWdata != keyReg) && !wdReset) |=> wdReset);

  // R13: reset request is a single-cycle pulse
  a_r13_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);

  // R12: a zero key never leaves zero while armed
  a_r12_zero_stuck: assert property (@(posedge clk) disable iff (!rstN)
    (locked && keyReg == '0) |=> (keyReg == '0));

  // R9: an unarmed clear always drops the interrupt
  a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && !locked) |=> !irq);
endmodule

// File: rtl/kickTimer.sv
module kickTimer
  import kt_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter int               KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_TAPS = 8'h63
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWe,
  input  logic [CTRL_USED-1:0] ctrlWdata,
  output logic [CTRL_W-1:0]    ctrlRdata,
  input  logic                 loadWe,
  input  logic [CNT_W-1:0]     loadWdata,
  input  logic                 clrWe,
  input  logic [KEY_W-1:0]     clrWdata,
  input  logic                 tick,
  input  logic                 pwrDown,
  output logic [CNT_W-1:0]     count,
  output logic                 irq,
  output logic                 wdReset
);
  localparam int PAD_W = CTRL_W - CTRL_USED;

  dpStrobes_t           strobes;
  logic                 atLimit;
  logic [CTRL_USED-1:0] ctrlQ;

  ktControl #(.KEY_W(KEY_W), .KEY_TAPS(KEY_TAPS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .clrWe    (clrWe),
    .clrWdata (clrWdata),
    .loadWe   (loadWe),
    .tick     (tick),
    .pwrDown  (pwrDown),
    .atLimit  (atLimit),
    .strobes  (strobes),
    .ctrlQ    (ctrlQ),
    .irq      (irq),
    .wdReset  (wdReset)
  );

  ktDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadWdata(loadWdata),
    .count    (count),
    .atLimit  (atLimit)
  );

  assign ctrlRdata = {{PAD_W{1'b0}}, ctrlQ};
endmodule

// File: tb/kickTimer_tb_top.sv
module kickTimer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 65535;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [8:0]  ctrlWdata = '0;
  logic [16:0] ctrlRdata;
  logic        loadWe = 1'b0;
  logic [15:0] loadWdata = '0;
  logic        clrWe = 1'b0;
  logic [7:0]  clrWdata = '0;
  logic        tick = 1'b0;
  logic        pwrDown = 1'b0;
  logic [15:0] count;
  logic        irq;
  logic        wdReset;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  kickTimer dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .loadWe(loadWe), .loadWdata(loadWdata),
    .clrWe(clrWe), .clrWdata(clrWdata), .tick(tick), .pwrDown(pwrDown),
    .count(count), .irq(irq), .wdReset(wdReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int mCount = 0, mLoad = 0, mCtrl = 0, mKey = 0, mIrq = 0, mRst = 0, mArmed = 0;
  int nCount, nKey, nIrq, nRst;
  bit goodKick, badKick, adv, atEnd, fired;

  function automatic int nextKey(input int v);
    int s;
    s = (v * 2) % 256;
    if (v >= 128) s = s ^ 99;
    return s;
  endfunction

  function automatic bit bitOf(input int v, input int b);
    return ((v >> b) & 1) == 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mLoad = 0; mCtrl = 0; mKey = 0; mIrq = 0; mRst = 0; mArmed = 0;
    end else begin
      goodKick = clrWe && (mArmed == 0 || !bitOf(mCtrl, 4) ||
                           (int'(clrWdata) == mKey && mKey != 0));
      badKick  = clrWe && !goodKick;
      adv      = !goodKick && !loadWe && tick && bitOf(mCtrl, 7) &&
                 !(bitOf(mCtrl, 0) && pwrDown);
      atEnd    = bitOf(mCtrl, 8) ? (mCount == MAXC) : (mCount == 0);
      fired    = adv && atEnd;
      nCount = mCount;
      if (goodKick)    nCount = mLoad;
      else if (loadWe) nCount = int'(loadWdata);
      else if (adv) begin
        if (fired && bitOf(mCtrl, 6)) nCount = mLoad;
        else if (bitOf(mCtrl, 8))     nCount = (mCount + 1) % 65536;
        else                          nCount = (mCount + 65535) % 65536;
      end
      nIrq = mIrq;
      if (goodKick) nIrq = 0;
      else if (fired && !(mArmed == 1 && !bitOf(mCtrl, 1))) nIrq = 1;
      nRst = ((badKick || (fired && mArmed == 1 && !bitOf(mCtrl, 1))) && mRst == 0) ? 1 : 0;
      nKey = mKey;
      if (clrWe && mArmed == 0) nKey = int'(clrWdata);
      else if (goodKick && bitOf(mCtrl, 4)) nKey = nextKey(mKey);
      if (loadWe) mLoad = int'(loadWdata);
      if (ctrlWe && mArmed == 0) begin
        mCtrl = int'(ctrlWdata);
        if (bitOf(mCtrl, 5)) mArmed = 1;
      end
      mCount = nCount; mIrq = nIrq; mRst = nRst; mKey = nKey;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    chk("R2", "model count", int'(count), mCount);
    chk("R6", "model irq", int'(irq), mIrq);
    chk("R13", "model wdReset", int'(wdReset), mRst);
    chk("R1", "model ctrlRdata", int'(ctrlRdata), mCtrl);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask
  task automatic wrCtrl(input int v);
    ctrlWe = 1'b1; ctrlWdata = v[8:0]; @(negedge clk); ctrlWe = 1'b0;
  endtask
  task automatic wrLoad(input int v);
    loadWe = 1'b1; loadWdata = v[15:0]; @(negedge clk); loadWe = 1'b0;
  endtask
  task automatic kick(input int v);
    clrWe = 1'b1; clrWdata = v[7:0]; @(negedge clk); clrWe = 1'b0;
  endtask
  task automatic pulseTick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    doReset();
    chk("R5", "reset count", int'(count), 0);
    chk("R5", "reset irq", int'(irq), 0);
    chk("R5", "reset wdReset", int'(wdReset), 0);
    chk("R5", "reset ctrl", int'(ctrlRdata), 0);

    // R1 readback with reserved-bit zeros
    wrCtrl(9'h1DF);
    chk("R1", "readback", int'(ctrlRdata), 'h1DF);
    wrCtrl(0);

    // R5 / R2
    wrLoad(5);
    chk("R5", "load copy", int'(count), 5);
    wrCtrl('h080);
    for (int i = 0; i < 3; i++) pulseTick();
    chk("R2", "down count", int'(count), 2);
    wrCtrl('h000);
    pulseTick();
    chk("R2", "disabled hold", int'(count), 2);

    // R3 power-down stop
    wrCtrl('h081);
    pwrDown = 1'b1;
    pulseTick();
    chk("R3", "pd stop hold", int'(count), 2);
    wrCtrl('h080);
    pulseTick();
    chk("R3", "pd ignored", int'(count), 1);
    pwrDown = 1'b0;

    // R1 reserved prescaler code still divides by one
    wrCtrl('h08C);
    pulseTick();
    chk("R1", "prescaler 11 step", int'(count), 0);
    chk("R1", "prescaler readback", int'(ctrlRdata), 'h08C);

    // R4 periodic reload, R6 irq, R9 clear
    wrLoad(2);
    wrCtrl('h0C0);
    pulseTick(); pulseTick(); pulseTick();
    chk("R4", "periodic reload", int'(count), 2);
    chk("R6", "irq set", int'(irq), 1);
    kick('h55);
    chk("R9", "irq cleared", int'(irq), 0);
    chk("R9", "clear reload", int'(count), 2);

    // R4 free-running wrap down and up
    wrLoad(0);
    wrCtrl('h080);
    pulseTick();
    chk("R4", "wrap down", int'(count), 'hFFFF);
    chk("R6", "irq on wrap", int'(irq), 1);
    wrLoad('hFFFE);
    wrCtrl('h180);
    pulseTick();
    chk("R2", "up count", int'(count), 'hFFFF);
    pulseTick();
    chk("R4", "wrap up", int'(count), 0);

    // R10 / R11 / R13 / R8 secure sequence
    doReset();
    kick('hAA);
    wrLoad(10);
    wrCtrl('h0F0);
    pulseTick(); pulseTick();
    chk("R2", "wd counting", int'(count), 8);
    kick('hAA);
    chk("R10", "kick AA reload", int'(count), 10);
    chk("R10", "kick AA no reset", int'(wdReset), 0);
    pulseTick();
    kick('h37);
    chk("R10", "kick 37 reload", int'(count), 10);
    kick('h6E);
    chk("R10", "kick 6E no reset", int'(wdReset), 0);
    pulseTick();
    kick('h66);
    chk("R11", "bad kick reset", int'(wdReset), 1);
    chk("R11", "bad kick no reload", int'(count), 9);
    @(negedge clk);
    chk("R13", "pulse ends", int'(wdReset), 0);
    wrCtrl('h000);
    chk("R8", "ctrl frozen", int'(ctrlRdata), 'h0F0);
    kick('hDC);
    chk("R11", "key kept after bad kick", int'(count), 10);
    chk("R10", "kick DC no reset", int'(wdReset), 0);
    kick('hDB);
    chk("R10", "kick DB no reset", int'(wdReset), 0);

    // R7 watchdog expiry resets
    doReset();
    wrLoad(2);
    wrCtrl('h0E0);
    pulseTick(); pulseTick(); pulseTick();
    chk("R7", "expiry reset", int'(wdReset), 1);
    chk("R7", "no irq", int'(irq), 0);
    chk("R4", "wd reload", int'(count), 2);

    // R6 irq instead of reset
    doReset();
    wrLoad(1);
    wrCtrl('h0E2);
    pulseTick(); pulseTick();
    chk("R6", "wd irq", int'(irq), 1);
    chk("R6", "wd irq no reset", int'(wdReset), 0);
    kick('h12);
    chk("R9", "non-secure kick clears irq", int'(irq), 0);
    chk("R9", "non-secure kick reload", int'(count), 1);

    // R12 zero seed
    doReset();
    kick('h00);
    wrCtrl('h0B0);
    kick('h00);
    chk("R12", "zero seed reset", int'(wdReset), 1);

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule